// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a processor against runaway software. A hidden 16-bit up-counter advances on one of two tick enables. When it reaches the selected terminal count it sets a timeout flag. In watchdog mode it also requests a soft reset of the chip. In interval mode it wraps silently and can raise an interrupt instead, which turns the same hardware into a periodic tick source.

Software controls the block through one 16-bit control register. A write is accepted only when its upper byte carries the write key 0x5A. Any write with another upper byte is treated as a fault and requests a soft reset at once. Reads return 0x69 in the upper byte, so a read-modify-write of the register also trips a reset. Software keeps the watchdog quiet by writing the clear bit with a valid key before the terminal count is reached.

The control bits and the flag survive the soft reset that the block itself requests. Only the power-on reset input clears them.

Top module: `wdog_timer`

## Requirements
- R1: While `por_n` is low, `rdata` reads 0x6900, and `flag`, `rst_req` and `irq` are 0.
- R2: A write with upper byte 0x5A loads the control fields. The low-byte layout is: bits 1:0 interval select, bit 2 source select, bit 3 clear, bit 4 mode, bit 5 interrupt enable, bit 7 hold. Reads return 0x69 in bits 15:8, the flag in bit 6, and 0 in bit 3.
- R3: A write with any other upper byte leaves the control fields unchanged. It drives `rst_req` high in the cycle after the write edge and zeroes the counter.
- R4: A valid write with bit 3 set zeroes the counter. A valid write with bit 3 clear leaves the count untouched.
- R5: The interval select sets the terminal count: 00 gives 32768 ticks, 01 gives 8192, 10 gives 512 and 11 gives 64. These are taps at counter bits 15, 13, 9 and 6.
- R6: With source select 0 the counter advances on `sys_tick`. With source select 1 it advances on `aux_tick` only.
- R7: While hold is 1 the counter does not advance. Hold is 0 after power-on, so the timer runs at once on `sys_tick` with the 32768 period.
- R8: In watchdog mode (bit 4 = 0), reaching the terminal count sets the flag and pulses `rst_req` for exactly one cycle. The counter then restarts from 0.
- R9: In interval mode (bit 4 = 1), reaching the terminal count sets the flag and never asserts `rst_req`. The counter wraps to 0 and keeps counting.
- R10: `irq` is high exactly when the flag, the interrupt enable and `gie` are all 1. A cycle with `irq_ack` high clears the flag.
- R11: The flag and the control fields keep their values across a soft reset raised by `rst_req`. Asserting `por_n` low clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wdata | input | 16 | Write data: key in bits 15:8, control fields in bits 7:0 |
| rdata | output | 16 | Read value: 0x69 key, then control fields and flag |
| sys_tick | input | 1 | Fast tick enable |
| aux_tick | input | 1 | Slow tick enable |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq | output | 1 | Interrupt request |
| flag | output | 1 | Timeout flag, available for polling |
| rst_req | output | 1 | Single-cycle soft-reset request |

## Verification
The counter is hidden, so a wrong count shows up only as an expiry on the wrong edge. The bench therefore measures the exact number of tick edges from a write or acknowledge to the flag, for each tap, each source and each hold pattern. A missed or spurious clear moves that edge by the distance the counter had already run, which is seen within one period. Key faults and mode faults show on `rst_req` one cycle after the write or expiry edge. Lost retention shows on `rdata` in the first read after a soft reset.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int         CNT_W  = 16,
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69,
  parameter int         TAP0   = 15,
  parameter int         TAP1   = 13,
  parameter int         TAP2   = 9,
  parameter int         TAP3   = 6
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        sys_tick,
  input  logic        aux_tick,
  input  logic        gie,
  input  logic        irq_ack,
  output logic        irq,
  output logic        flag,
  output logic        rst_req
);
  logic [1:0]       isel;
  logic             src, mode, ie, hold;
  logic [CNT_W-1:0] cnt;

  wire key_ok = (wdata[15:8] == WR_KEY);
  wire wr_ok  = wr_en & key_ok;
  wire wr_bad = wr_en & ~key_ok;
  wire tick   = src ? aux_tick : sys_tick;
  wire step   = tick & ~hold;

  wire [CNT_W-1:0] cnt_nx = cnt + 1'b1;
  wire [3:0] taps = {cnt_nx[TAP3], cnt_nx[TAP2], cnt_nx[TAP1], cnt_nx[TAP0]};
  wire expire = step & taps[isel];
  wire zero_cnt = wr_bad | expire | (wr_ok & wdata[3]);

  wire unused_ok = &{1'b0, wdata[6]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      isel    <= '0;
      src     <= 1'b0;
      mode    <= 1'b0;
      ie      <= 1'b0;
      hold    <= 1'b0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
      cnt     <= '0;
    end else begin
      rst_req <= wr_bad | (expire & ~mode);
      if (wr_ok) begin
        isel <= wdata[1:0];
        src  <= wdata[2];
        mode <= wdata[4];
        ie   <= wdata[5];
        hold <= wdata[7];
      end
      if (zero_cnt)  cnt <= '0;
      else if (step) cnt <= cnt_nx;
      if (expire)       flag <= 1'b1;
      else if (irq_ack) flag <= 1'b0;
    end
  end

  assign rdata = {RD_KEY, hold, flag, ie, mode, 1'b0, src, isel};
  assign irq   = flag & ie & gie;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             wr_en,
  input logic [15:0]      wdata,
  input logic [15:0]      rdata,
  input logic             flag,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt
);
  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  assert_bad_key_R3: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[15:8] != 8'h5A) |=> rst_req);

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!por_n)
    (rdata[7] && !wr_en) |=> (cnt == $past(cnt)));

  assert_interval_no_reset_R9: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(flag) && rdata[4] && !$past(wr_en)) |-> !rst_req);

  assert_wdog_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(flag) && !rdata[4] && !$past(wr_en)) |-> rst_req);

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[15:8] == 8'h5A && wdata[3]) |=> (cnt == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .flag(flag), .rst_req(rst_req), .cnt(cnt)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  logic clk = 1'b0;
  logic por_n = 1'b0, wr_en = 1'b0, sys_tick = 1'b1, aux_tick = 1'b0;
  logic gie = 1'b0, irq_ack = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, flag, rst_req;
  int errors = 0, checks = 0, cycles = 0;
  bit rst_seen;

  always #2 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .sys_tick(sys_tick), .aux_tick(aux_tick), .gie(gie), .irq_ack(irq_ack),
    .irq(irq), .flag(flag), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) rst_seen = 1'b1;
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic measure(output int n, input int lim);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
      if (rst_req) rst_seen = 1'b1;
    end while (!flag && n < lim);
  endtask

  task automatic t_reset_and_default();
    int n;
    step(3);
    chk(rdata == 16'h6900, "R1 rdata", rdata, 16'h6900);
    chk(!flag && !rst_req && !irq, "R1 outputs", {flag, rst_req, irq}, 0);
    por_n = 1'b1;
    measure(n, 40000);
    chk(n == 32768, "R5/R7 default period", n, 32768);
    chk(rst_req == 1'b1, "R8 reset request", rst_req, 1);
    step(1);
    chk(rst_req == 1'b0, "R8 single pulse", rst_req, 0);
    chk(rdata == 16'h6940, "R11 retained after soft reset", rdata, 16'h6940);
    ack();
    chk(!flag, "R10 ack clears flag", flag, 0);
  endtask

  task automatic t_interval_irq();
    int n;
    wr(16'h5A3B);
    chk(rdata == 16'h6933, "R2 readback", rdata, 16'h6933);
    rst_seen = 1'b0;
    measure(n, 200);
    chk(n == 64, "R4/R5 clear then 64 ticks", n, 64);
    chk(!irq, "R10 gie low masks irq", irq, 0);
    gie = 1'b1; #1;
    chk(irq, "R10 irq raised", irq, 1);
    ack();
    chk(!flag && !irq, "R10 ack drops irq", {flag, irq}, 0);
    measure(n, 200);
    chk(n == 63, "R9 wrap period", n, 63);
    chk(!rst_seen, "R9 no reset in interval mode", rst_seen, 0);
    ack();
    gie = 1'b0;
  endtask

  task automatic t_bad_key();
    int n;
    wr(16'hA51B);
    chk(rst_req, "R3 reset on bad key", rst_req, 1);
    chk(rdata == 16'h6933, "R3 control unchanged", rdata, 16'h6933);
    step(1);
    chk(!rst_req, "R3 pulse ends", rst_req, 0);
    measure(n, 200);
    chk(n == 63, "R3 counter zeroed", n, 63);
    ack();
  endtask

  task automatic t_taps();
    int n;
    wr(16'h5A19);
    measure(n, 9000);
    chk(n == 8192, "R5 select 01", n, 8192);
    ack();
    wr(16'h5A1A);
    measure(n, 1000);
    chk(n == 512, "R5 select 10", n, 512);
    ack();
  endtask

  task automatic t_source();
    wr(16'h5A1F);
    step(300);
    chk(!flag, "R6 sys tick ignored", flag, 0);
    for (int i = 0; i < 63; i++) begin
      aux_tick = 1'b1; step(1); aux_tick = 1'b0; step(1);
    end
    chk(!flag, "R6 63 aux ticks", flag, 0);
    aux_tick = 1'b1; step(1); aux_tick = 1'b0;
    chk(flag, "R6 64th aux tick", flag, 1);
    ack();
  endtask

  task automatic t_hold();
    int n;
    wr(16'h5A1B);
    step(30);
    wr(16'h5A93);
    step(100);
    chk(!flag, "R7 held", flag, 0);
    chk(rdata == 16'h6993, "R7 hold readback", rdata, 16'h6993);
    wr(16'h5A13);
    measure(n, 200);
    chk(n == 33, "R4/R7 count kept through hold", n, 33);
  endtask

  task automatic t_por();
    wr(16'h5A3B);
    chk(rdata == 16'h6973, "R11 before por", rdata, 16'h6973);
    por_n = 1'b0; #1;
    chk(rdata == 16'h6900 && !flag, "R11 por clears", rdata, 16'h6900);
    step(2);
    por_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_default();
    t_interval_irq();
    t_bad_key();
    t_taps();
    t_source();
    t_hold();
    t_por();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule